// File: doc/BRIEF.md
# Adaptive Proportional-Integral Loop Filter

This block is the loop filter of an all-digital phase-locked loop. Once per reference cycle, a strobe delivers a signed phase-error word. The word is either a multi-bit time-to-digital result or a single early/late decision. The filter turns it into a signed oscillator control code. That code is a proportional term plus a running integral. A parameterised cascade of first-order low-pass stages then smooths it before it leaves the block.

All gains are powers of two, so every product is a shift and the block needs no multipliers. After reset the filter starts from a programmable preset code, using wide acquisition gains. Once a lock indication has held for a programmable number of updates, the filter moves to narrow tracking gains. It returns to the acquisition gains as soon as the lock indication drops. The integrator and the sum saturate at the ends of the code range and never wrap.

Top module: `pi_loop_filter`

## Requirements
- R1: While reset is held and after it is released, before any update: `out_code` equals `preset_int`, `out_vld` is 0 and `trk_active` is 0 (acquisition gains in force). Reset is synchronous and active low.
- R2: `out_vld` is 1 in exactly the cycle after each clock edge where `upd_vld` is 1, and 0 otherwise. `out_code` changes only in the cycle after an update.
- R3: On an update with error e, the integrator I becomes sat(I + e·2^a) and the sum P becomes sat(I_new + e·2^b). Here e is `err_in` read as two's complement, a is the alpha shift and b is the beta shift.
- R4: When `bb_mode` is 1, the error is +1 if `bb_early` is 1 and -1 if it is 0, and `err_in` has no effect.
- R5: The integrator saturates at -2^(CODE_W-1) and 2^(CODE_W-1)-1 and never wraps.
- R6: The proportional-plus-integral sum saturates at the same two limits before it enters the low-pass cascade.
- R7: Each of the LP_STAGES low-pass stages, in order, holds a state s that is updated as s + ((x - s) >>> `lp_sh`), where x is the new value from the stage before it and >>> is a floor shift. `out_code` is the new state of the last stage. With `lp_sh` = 0, a stage passes its input straight through.
- R8: `trk_active` rises after the update on which `lock_in` has been 1 on `lock_len` consecutive updates. A `lock_len` of 0 counts as 1.
- R9: Any update with `lock_in` = 0 clears `trk_active` and restarts the lock count.
- R10: An update uses the gain set in force before it: acquisition shifts while `trk_active` is 0, tracking shifts while it is 1. The integrator value carries over unchanged across a gain switch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| upd_vld | input | 1 | Update strobe, one per reference edge |
| bb_mode | input | 1 | 1 selects the single-bit early/late error |
| bb_early | input | 1 | Early (1) or late (0) decision |
| err_in | input | ERR_W | Signed multi-bit phase error |
| lock_in | input | 1 | Lock indication, sampled on updates |
| lock_len | input | LOCK_W | Consecutive locked updates before switching gains |
| acq_alpha_sh | input | SH_W | Integral shift, acquisition |
| acq_beta_sh | input | SH_W | Proportional shift, acquisition |
| trk_alpha_sh | input | SH_W | Integral shift, tracking |
| trk_beta_sh | input | SH_W | Proportional shift, tracking |
| lp_sh | input | SH_W | Low-pass smoothing shift |
| preset_int | input | CODE_W | Reset value of the integrator, stages and output |
| out_code | output | CODE_W | Signed oscillator control code |
| out_vld | output | 1 | Output-valid pulse, one cycle after an update |
| trk_active | output | 1 | 1 while tracking gains are in force |

## Verification
The hardest situation to reach is the update that crosses a gain switch while the integrator sits at a rail. That update must use the previous gain set, keep the saturated integrator and still produce the right smoothed code. The stimulus gets there by driving long runs of large same-sign errors with big acquisition shifts, which pins the integrator at a limit. It holds `lock_in` through a short `lock_len`, with `lock_len` of 0 included. Random runs then vary the lock, the shifts and the error mode on every update, so switches keep landing in saturated and unsaturated states.

// File: rtl/pi_loop_filter.sv
module pi_loop_filter #(
  parameter int ERR_W     = 8,
  parameter int CODE_W    = 12,
  parameter int SH_W      = 4,
  parameter int LP_STAGES = 2,
  parameter int LOCK_W    = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     upd_vld,
  input  logic                     bb_mode,
  input  logic                     bb_early,
  input  logic signed [ERR_W-1:0]  err_in,
  input  logic                     lock_in,
  input  logic [LOCK_W-1:0]        lock_len,
  input  logic [SH_W-1:0]          acq_alpha_sh,
  input  logic [SH_W-1:0]          acq_beta_sh,
  input  logic [SH_W-1:0]          trk_alpha_sh,
  input  logic [SH_W-1:0]          trk_beta_sh,
  input  logic [SH_W-1:0]          lp_sh,
  input  logic signed [CODE_W-1:0] preset_int,
  output logic signed [CODE_W-1:0] out_code,
  output logic                     out_vld,
  output logic                     trk_active
);
  localparam int WW = ERR_W + (1 << SH_W) + 2;
  localparam int SW = ((WW > CODE_W) ? WW : CODE_W) + 2;
  localparam logic signed [SW-1:0] CMAX = {{(SW-CODE_W+1){1'b0}}, {(CODE_W-1){1'b1}}};
  localparam logic signed [SW-1:0] CMIN = ~CMAX;

  function automatic logic signed [CODE_W-1:0] sat(input logic signed [SW-1:0] v);
    if (v > CMAX)      sat = CMAX[CODE_W-1:0];
    else if (v < CMIN) sat = CMIN[CODE_W-1:0];
    else               sat = v[CODE_W-1:0];
  endfunction

  logic signed [CODE_W-1:0] integ_q, out_q;
  logic [LOCK_W-1:0]        cnt_q;
  logic                     trk_q, vld_q;

  logic signed [ERR_W-1:0]  err;
  logic signed [SW-1:0]     err_x, inc, prop;
  logic [SH_W-1:0]          a_sh, b_sh;
  logic signed [CODE_W-1:0] int_nxt, pi_nxt;
  logic signed [CODE_W-1:0] lp_in [LP_STAGES+1];
  logic                     lock_hit;

  assign err   = bb_mode ? {{(ERR_W-1){~bb_early}}, 1'b1} : err_in;
  assign err_x = {{(SW-ERR_W){err[ERR_W-1]}}, err};
  assign a_sh  = trk_q ? trk_alpha_sh : acq_alpha_sh;
  assign b_sh  = trk_q ? trk_beta_sh  : acq_beta_sh;
  assign inc   = err_x <<< a_sh;
  assign prop  = err_x <<< b_sh;
  assign int_nxt = sat({{(SW-CODE_W){integ_q[CODE_W-1]}}, integ_q} + inc);
  assign pi_nxt  = sat({{(SW-CODE_W){int_nxt[CODE_W-1]}}, int_nxt} + prop);
  assign lp_in[0] = pi_nxt;

  for (genvar k = 0; k < LP_STAGES; k++) begin : g_lp
    logic signed [CODE_W-1:0] s_q;
    logic signed [CODE_W:0]   diff, stp;
    assign diff = {lp_in[k][CODE_W-1], lp_in[k]} - {s_q[CODE_W-1], s_q};
    assign stp  = diff >>> lp_sh;
    assign lp_in[k+1] = s_q + stp[CODE_W-1:0];
    always_ff @(posedge clk) begin
      if (!rst_n)       s_q <= preset_int;
      else if (upd_vld) s_q <= lp_in[k+1];
    end
  end

  assign lock_hit = ({1'b0, cnt_q} + 1'b1) >= {1'b0, lock_len};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      integ_q <= preset_int;
      out_q   <= preset_int;
      cnt_q   <= '0;
      trk_q   <= 1'b0;
      vld_q   <= 1'b0;
    end else begin
      vld_q <= upd_vld;
      if (upd_vld) begin
        integ_q <= int_nxt;
        out_q   <= lp_in[LP_STAGES];
        if (!lock_in) begin
          trk_q <= 1'b0;
          cnt_q <= '0;
        end else if (!trk_q) begin
          if (lock_hit) begin
            trk_q <= 1'b1;
            cnt_q <= '0;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
      end
    end
  end

  assign out_code   = out_q;
  assign out_vld    = vld_q;
  assign trk_active = trk_q;
endmodule

module pi_loop_filter_chk #(
  parameter int CODE_W = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              upd_vld,
  input logic              lock_in,
  input logic [CODE_W-1:0] out_code,
  input logic              out_vld,
  input logic              trk_active
);
  // R2
  vld_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    upd_vld |=> out_vld);
  // R2
  no_spurious_vld_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_vld |=> !out_vld);
  // R2
  code_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_vld |=> $stable(out_code));
  // R9
  lock_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_vld && !lock_in) |=> !trk_active);
  // R8
  trk_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(trk_active) |-> $past(upd_vld && lock_in));
endmodule

bind pi_loop_filter pi_loop_filter_chk #(.CODE_W(CODE_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .upd_vld(upd_vld), .lock_in(lock_in),
  .out_code(out_code), .out_vld(out_vld), .trk_active(trk_active));

// File: tb/pi_loop_filter_tb.sv
`timescale 1ns/1ps
module pi_loop_filter_tb_top;
  localparam int ERR_W = 8, CODE_W = 12, SH_W = 4, NST = 2, LOCK_W = 8;
  localparam longint LIM = 2047;

  logic clk = 0, rst_n = 0, upd_vld = 0, bb_mode = 0, bb_early = 0, lock_in = 0;
  logic signed [ERR_W-1:0] err_in = 0;
  logic [LOCK_W-1:0] lock_len = 0;
  logic [SH_W-1:0] aa = 0, ab = 0, ta = 0, tb = 0, lps = 0;
  logic signed [CODE_W-1:0] preset_int = 0, out_code;
  logic out_vld, trk_active;

  always #5 clk = ~clk;

  pi_loop_filter #(.ERR_W(ERR_W), .CODE_W(CODE_W), .SH_W(SH_W), .LP_STAGES(NST), .LOCK_W(LOCK_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .upd_vld(upd_vld), .bb_mode(bb_mode), .bb_early(bb_early),
    .err_in(err_in), .lock_in(lock_in), .lock_len(lock_len), .acq_alpha_sh(aa),
    .acq_beta_sh(ab), .trk_alpha_sh(ta), .trk_beta_sh(tb), .lp_sh(lps),
    .preset_int(preset_int), .out_code(out_code), .out_vld(out_vld), .trk_active(trk_active));

  int errors = 0, checks = 0;
  longint m_int, m_out;
  longint m_s [NST];
  bit m_trk;
  int m_cnt;

  task automatic chk(bit ok, string tag, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic longint sat(longint v);
    if (v > LIM) return LIM;
    if (v < -LIM - 1) return -LIM - 1;
    return v;
  endfunction

  task automatic model_reset(longint p);
    m_int = p; m_out = p; m_trk = 0; m_cnt = 0;
    for (int k = 0; k < NST; k++) m_s[k] = p;
  endtask

  task automatic model_update();
    longint e, x;
    int a, b;
    e = bb_mode ? (bb_early ? 1 : -1) : longint'(err_in);
    a = m_trk ? int'(ta) : int'(aa);
    b = m_trk ? int'(tb) : int'(ab);
    m_int = sat(m_int + e * (longint'(1) << a));
    x = sat(m_int + e * (longint'(1) << b));
    for (int k = 0; k < NST; k++) begin
      m_s[k] = m_s[k] + ((x - m_s[k]) >>> lps);
      x = m_s[k];
    end
    m_out = x;
    if (!lock_in) begin m_trk = 0; m_cnt = 0; end
    else if (!m_trk) begin
      if (m_cnt + 1 >= int'(lock_len)) begin m_trk = 1; m_cnt = 0; end
      else m_cnt++;
    end
  endtask

  task automatic do_update(string tag);
    @(negedge clk);
    upd_vld = 1;
    @(negedge clk);
    upd_vld = 0;
    model_update();
    chk(out_vld === 1'b1, {tag, " R2 vld"}, out_vld, 1);
    chk(out_code == m_out, {tag, " code"}, out_code, m_out);
    chk(trk_active == m_trk, {tag, " trk"}, trk_active, m_trk);
  endtask

  task automatic idle_check(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      chk(out_vld === 1'b0, "R2 idle vld", out_vld, 0);
      chk(out_code == m_out, "R2 idle hold", out_code, m_out);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    preset_int = 12'sd100;
    aa = 2; ab = 4; ta = 0; tb = 1; lps = 1; lock_len = 3;
    repeat (4) @(negedge clk);
    // R1 during reset
    chk(out_code == 100 && out_vld == 0 && trk_active == 0, "R1 in reset", out_code, 100);
    rst_n = 1;
    model_reset(100);
    idle_check(2); // R1 after release
    chk(trk_active == 0, "R1 acq mode", trk_active, 0);

    // R3 multi-bit errors, R7 smoothing
    err_in = 3;  do_update("R3 pos");
    err_in = -5; do_update("R3 neg");
    lps = 0; err_in = 0; do_update("R7 passthru");
    chk(out_code == m_int, "R7 lp_sh=0 equals integrator", out_code, m_int);
    lps = 2; err_in = 7; do_update("R7 shift2");
    idle_check(3);

    // R4 bang-bang, err_in ignored
    bb_mode = 1; lps = 0; aa = 1; ab = 3;
    bb_early = 1; err_in = 8'sh7f;   do_update("R4 early");
    bb_early = 0; err_in = 8'sh7f;   do_update("R4 late");
    bb_early = 0; err_in = -8'sd128; do_update("R4 late2");
    bb_mode = 0;

    // R5 R6 saturation high
    aa = 8; ab = 8; lps = 0; err_in = 127;
    for (int i = 0; i < 4; i++) do_update("R5 sat hi");
    chk(out_code == LIM, "R6 output at max", out_code, LIM);
    // R10 lock while saturated, switch keeps integrator
    lock_in = 1; lock_len = 3; ta = 0; tb = 0; err_in = -1;
    do_update("R8 lock1");
    do_update("R8 lock2");
    chk(trk_active == 0, "R8 not yet", trk_active, 0);
    do_update("R8 lock3");
    chk(trk_active == 1, "R8 switched", trk_active, 1);
    do_update("R10 first tracking update");
    // R9
    lock_in = 0; do_update("R9 drop");
    chk(trk_active == 0, "R9 back to acq", trk_active, 0);
    // R8 lock_len 0
    lock_in = 1; lock_len = 0; do_update("R8 len0");
    chk(trk_active == 1, "R8 len0 one update", trk_active, 1);
    lock_in = 0;
    // R5 saturation low
    aa = 9; ab = 9; err_in = -128;
    for (int i = 0; i < 4; i++) do_update("R5 sat lo");
    chk(out_code == -LIM - 1, "R6 output at min", out_code, -LIM - 1);

    // random mix
    for (int i = 0; i < 3000; i++) begin
      aa = SH_W'($urandom_range(0, 7)); ab = SH_W'($urandom_range(0, 8));
      ta = SH_W'($urandom_range(0, 3)); tb = SH_W'($urandom_range(0, 4));
      lps = SH_W'($urandom_range(0, 3));
      err_in = ERR_W'($urandom);
      if ($urandom_range(0, 3) == 0) err_in = err_in >>> 4;
      bb_mode = ($urandom_range(0, 2) == 0);
      bb_early = $urandom_range(0, 1) != 0;
      lock_in = ($urandom_range(0, 9) != 0);
      lock_len = LOCK_W'($urandom_range(0, 6));
      do_update("R3 R7 R8 R10 random");
      if ($urandom_range(0, 4) == 0) idle_check($urandom_range(1, 2));
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule